// File: doc/BRIEF.md
# Pipelined Radix-2 Unsigned Divider

This block divides an unsigned 10-bit dividend by an unsigned 8-bit divisor. It returns a 10-bit integer quotient and an 8-bit integer remainder. Each pipeline stage resolves one quotient bit by a restoring shift-and-subtract step, so the datapath holds one stage per dividend bit. The stages sit between one register that captures the operands and one register that drives the results. A new operand pair can enter on every rising edge, and one result leaves per clock after a fixed delay.

A ready flag shows when the operands are being sampled. It is low only while reset is active and on the first edge after reset. A valid bit travels with each operand pair, so the consumer sees exactly one output-valid pulse per accepted request. A zero divisor does not stall the pipeline. It produces a defined result instead.

The widths and the trial-subtract variant are parameters. Elaboration checks reject widths that the structure cannot support.

Top module: `pdiv_pipe`

## Requirements
- R1: While `rst` is high, `ready` and `out_valid` are low. `ready` goes high after the first rising edge at which `rst` is sampled low, and it stays high until the next reset.
- R2: For a nonzero divisor, an accepted pair (a, b) gives `quotient` = floor(a / b) and `remainder` = a mod b, both unsigned, across the full range (a from 0 to 1023, b from 1 to 255).
- R3: A pair is accepted at the rising edge E where `in_valid` and `ready` are both high. Counting E as edge 1, `out_valid` is high together with that pair's result after edge 12 (E+11), for exactly one cycle.
- R4: Pairs accepted on consecutive edges give results on consecutive cycles, in the order they were accepted.
- R5: An edge with `in_valid` low creates a bubble. Eleven edges later `out_valid` is low for one cycle, and the results on either side of the bubble are unaffected.
- R6: A zero divisor gives a quotient of all ones (1023) and a remainder equal to the low 8 bits of the dividend. It takes the same 12-edge latency and does not stall the pairs around it.
- R7: A request presented while `ready` is low, which includes the whole reset period, is dropped. It never produces an `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; the pipeline advances on every edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe for the operand pair |
| dividend | input | 10 | Unsigned dividend |
| divisor | input | 8 | Unsigned divisor |
| ready | output | 1 | High when the operands are sampled on the next edge |
| out_valid | output | 1 | Result qualifier |
| quotient | output | 10 | Unsigned integer quotient |
| remainder | output | 8 | Unsigned integer remainder |

## Verification
Directed pairs probe the arithmetic at its corners:
- Maximum dividend over divisors 1 and 255.
- Zero dividend.
- Equal operands, and a dividend one below the divisor.

These separate a wrong final quotient bit from a remainder that was not restored correctly. A 40-deep back-to-back stream of pseudo-random pairs exposes ordering and stage-to-stage hand-off faults that single requests cannot show. Alternating valid/idle requests show whether bubbles keep their position. Zero-divisor pairs placed between nonzero ones show that the all-ones rule stays inside its own stage, and requests issued during reset show that nothing leaks out of the input register.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

   // Implementation choice for the per-stage trial subtraction.
   typedef enum logic {
      TRIAL_SUB = 1'b0,   // one wide subtractor, borrow selects the result
      TRIAL_CMP = 1'b1    // magnitude comparator plus narrow subtractor
   } trial_e;

   // Edges from capture to visible result: input register, one per
   // quotient bit, output register.
   function automatic int unsigned pdiv_latency(input int unsigned dvd_w);
      return dvd_w + 2;
   endfunction

endpackage

// File: rtl/pdiv_in_reg.sv
module pdiv_in_reg #(
   parameter int unsigned DVD_W = 10,
   parameter int unsigned DVS_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [DVD_W-1:0] dvd_i,
   input  logic [DVS_W-1:0] dvs_i,
   output logic             rdy_o,
   output logic             v_o,
   output logic [DVD_W-1:0] dvd_o,
   output logic [DVS_W-1:0] dvs_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         rdy_o <= 1'b0;
         v_o   <= 1'b0;
      end else begin
         rdy_o <= 1'b1;
         v_o   <= in_valid & rdy_o;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid && rdy_o) begin
         dvd_o <= dvd_i;
         dvs_o <= dvs_i;
      end
   end

   // R7: a slot enters the pipe only if the request met a high ready flag
   a_r7_capture_needs_ready: assert property (@(posedge clk) disable iff (rst)
      v_o |-> $past(rdy_o && in_valid));

endmodule

// File: rtl/pdiv_stage.sv
module pdiv_stage
   import pdiv_pkg::*;
#(
   parameter int unsigned DVD_W = 10,
   parameter int unsigned DVS_W = 8,
   parameter trial_e      TRIAL = TRIAL_SUB
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             v_i,
   input  logic [DVD_W-1:0] dvd_i,   // unconsumed dividend bits, MSB next
   input  logic [DVS_W-1:0] rem_i,
   input  logic [DVD_W-1:0] quo_i,
   input  logic [DVS_W-1:0] dvs_i,
   output logic             v_o,
   output logic [DVD_W-1:0] dvd_o,
   output logic [DVS_W-1:0] rem_o,
   output logic [DVD_W-1:0] quo_o,
   output logic [DVS_W-1:0] dvs_o
);

   localparam int unsigned TW = DVS_W + 1;

   logic [TW-1:0]    trial;
   logic             ge;
   logic [DVS_W-1:0] rem_n;

   assign trial = {rem_i, dvd_i[DVD_W-1]};

   generate
      if (TRIAL == TRIAL_SUB) begin : g_sub
         logic [TW:0] diff;
         logic        unused_sub;
         assign diff       = {1'b0, trial} - {2'b00, dvs_i};
         assign ge         = ~diff[TW];
         assign rem_n      = ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
         assign unused_sub = diff[TW-1];
      end else begin : g_cmp
         assign ge    = trial >= {1'b0, dvs_i};
         assign rem_n = ge ? (trial[DVS_W-1:0] - dvs_i) : trial[DVS_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v_i;
   end

   always_ff @(posedge clk) begin
      dvd_o <= {dvd_i[DVD_W-2:0], 1'b0};
      rem_o <= rem_n;
      quo_o <= {quo_i[DVD_W-2:0], ge};
      dvs_o <= dvs_i;
   end

   // R3: the valid bit advances exactly one stage per edge
   a_r3_valid_step: assert property (@(posedge clk) disable iff (rst)
      v_o == $past(v_i));

   // R2: after every restoring step the partial remainder is below the divisor
   a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
      (v_o && dvs_o != '0) |-> (rem_o < dvs_o));

   // R6: with a zero divisor every step emits a one
   a_r6_zero_divisor_bit: assert property (@(posedge clk) disable iff (rst)
      (v_o && dvs_o == '0) |-> quo_o[0]);

endmodule

// File: rtl/pdiv_out_reg.sv
module pdiv_out_reg #(
   parameter int unsigned DVD_W = 10,
   parameter int unsigned DVS_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             v_i,
   input  logic [DVD_W-1:0] quo_i,
   input  logic [DVS_W-1:0] rem_i,
   output logic             v_o,
   output logic [DVD_W-1:0] quo_o,
   output logic [DVS_W-1:0] rem_o
);

   always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v_i;
   end

   always_ff @(posedge clk) begin
      quo_o <= quo_i;
      rem_o <= rem_i;
   end

   // R5: a bubble at the last stage becomes a low output-valid
   a_r5_bubble_kept: assert property (@(posedge clk) disable iff (rst)
      $past(!v_i) |-> !v_o);

endmodule

// File: rtl/pdiv_pipe.sv
module pdiv_pipe
   import pdiv_pkg::*;
#(
   parameter int unsigned DVD_W = 10,
   parameter int unsigned DVS_W = 8,
   parameter trial_e      TRIAL = TRIAL_SUB
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [9:0]       dividend,
   input  logic [7:0]       divisor,
   output logic             ready,
   output logic             out_valid,
   output logic [9:0]       quotient,
   output logic [7:0]       remainder
);

   localparam int unsigned NSTG = DVD_W;
   localparam int unsigned LAT  = pdiv_latency(DVD_W);

   generate
      if (DVD_W < 2) begin : g_bad_dvd
         $error("pdiv_pipe: DVD_W must be at least 2");
      end
      if (DVS_W < 1) begin : g_bad_dvs
         $error("pdiv_pipe: DVS_W must be at least 1");
      end
      if (DVD_W != 10 || DVS_W != 8) begin : g_bad_port
         $error("pdiv_pipe: port widths are fixed at 10/8");
      end
      if (LAT != NSTG + 2) begin : g_bad_lat
         $error("pdiv_pipe: latency rule broken");
      end
   endgenerate

   logic             v_s   [0:NSTG];
   logic [DVD_W-1:0] dvd_s [0:NSTG];
   logic [DVS_W-1:0] rem_s [0:NSTG];
   logic [DVD_W-1:0] quo_s [0:NSTG];
   logic [DVS_W-1:0] dvs_s [0:NSTG];
   logic             unused_tail;

   pdiv_in_reg #(.DVD_W(DVD_W), .DVS_W(DVS_W)) i_in (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .dvd_i    (dividend),
      .dvs_i    (divisor),
      .rdy_o    (ready),
      .v_o      (v_s[0]),
      .dvd_o    (dvd_s[0]),
      .dvs_o    (dvs_s[0])
   );

   assign rem_s[0] = '0;
   assign quo_s[0] = '0;

   generate
      for (genvar k = 0; k < NSTG; k++) begin : g_stg
         pdiv_stage #(.DVD_W(DVD_W), .DVS_W(DVS_W), .TRIAL(TRIAL)) i_stg (
            .clk   (clk),
            .rst   (rst),
            .v_i   (v_s[k]),
            .dvd_i (dvd_s[k]),
            .rem_i (rem_s[k]),
            .quo_i (quo_s[k]),
            .dvs_i (dvs_s[k]),
            .v_o   (v_s[k+1]),
            .dvd_o (dvd_s[k+1]),
            .rem_o (rem_s[k+1]),
            .quo_o (quo_s[k+1]),
            .dvs_o (dvs_s[k+1])
         );
      end
   endgenerate

   assign unused_tail = ^{dvd_s[NSTG], dvs_s[NSTG]};

   pdiv_out_reg #(.DVD_W(DVD_W), .DVS_W(DVS_W)) i_out (
      .clk   (clk),
      .rst   (rst),
      .v_i   (v_s[NSTG]),
      .quo_i (quo_s[NSTG]),
      .rem_i (rem_s[NSTG]),
      .v_o   (out_valid),
      .quo_o (quotient),
      .rem_o (remainder)
   );

   // R1: one edge with reset low is enough to raise ready
   a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> ready);

endmodule

// File: tb/test_pdiv_pipe.sv
module test_pdiv_pipe;

   localparam time CLK_PERIOD = 10ns;
   localparam int  LATE       = 11;     // capture edge + 11 = result edge
   localparam int  DEPTH      = 4096;
   localparam int  WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [9:0] dividend = '0;
   logic [7:0] divisor = '0;
   logic       ready, out_valid;
   logic [9:0] quotient;
   logic [7:0] remainder;

   int checks = 0;
   int errors = 0;
   int edge_n = 0;
   int first_low_edge = 1 << 30;
   int pulses = 0;

   bit        cap_v   [DEPTH];
   bit [9:0]  cap_a   [DEPTH];
   bit [7:0]  cap_b   [DEPTH];
   string     cap_tag [DEPTH];

   pdiv_pipe i_pdiv_pipe (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .dividend(dividend), .divisor(divisor),
      .ready(ready), .out_valid(out_valid),
      .quotient(quotient), .remainder(remainder)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) edge_n++;

   task automatic check(input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Scoreboard: compare every output slot against what was issued.
   always @(negedge clk) begin
      int idx;
      idx = edge_n - LATE;
      if (out_valid) pulses++;
      if (idx >= 1 && idx < DEPTH && edge_n > 1) begin
         string t;
         t = (cap_tag[idx] == "") ? "R5" : cap_tag[idx];
         check(t, "out_valid", int'(out_valid), int'(cap_v[idx]));
         if (cap_v[idx] && out_valid) begin
            if (cap_b[idx] == 0) begin
               // R6: zero divisor rule
               check("R6", "quotient", quotient, 1023);
               check("R6", "remainder", remainder, cap_a[idx] % 256);
            end else begin
               check(t, "quotient", quotient, cap_a[idx] / cap_b[idx]);
               check(t, "remainder", remainder, cap_a[idx] % cap_b[idx]);
            end
         end
      end
   end

   // Present one request for the coming edge (called right after a negedge).
   task automatic issue(input bit v, input int a, input int b, input string tag);
      int e;
      e = edge_n + 1;
      in_valid = v;
      dividend = 10'(a);
      divisor  = 8'(b);
      if (e < DEPTH) begin
         cap_v[e]   = v && (edge_n >= first_low_edge);
         cap_a[e]   = 10'(a);
         cap_b[e]   = 8'(b);
         cap_tag[e] = tag;
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) issue(1'b0, 0, 0, "R5");
   endtask

   // R1 / R7: reset state and requests during reset
   task automatic t_reset();
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         check("R1", "ready in reset", int'(ready), 0);
         check("R1", "out_valid in reset", int'(out_valid), 0);
         issue(1'b1, 100 + i, 3, "R7");
      end
      rst = 1'b0;
      first_low_edge = edge_n + 1;
      check("R1", "ready before first edge", int'(ready), 0);
      issue(1'b1, 77, 5, "R7");      // ready still low: dropped
      check("R1", "ready after first edge", int'(ready), 1);
      idle(14);
      check("R7", "pulses from dropped requests", pulses, 0);
   endtask

   // R3: single request latency measured by edge count
   task automatic t_single();
      int start, seen;
      pulses = 0;
      start = edge_n + 1;
      issue(1'b1, 529, 10, "R3");
      seen = -1;
      for (int i = 0; i < 16; i++) begin
         if (out_valid && seen < 0) seen = edge_n - start + 1;
         issue(1'b0, 0, 0, "R3");
      end
      check("R3", "edges to result", seen, 12);
      check("R3", "pulse count", pulses, 1);
   endtask

   // R2: arithmetic corners
   task automatic t_corners();
      int a[8] = '{1023, 1023, 0, 105, 255, 254, 529, 1000};
      int b[8] = '{1, 255, 7, 100, 255, 255, 10, 3};
      pulses = 0;
      for (int i = 0; i < 8; i++) issue(1'b1, a[i], b[i], "R2");
      idle(14);
      check("R2", "corner pulses", pulses, 8);
   endtask

   // R4: back-to-back pseudo-random stream
   task automatic t_stream();
      logic [17:0] lfsr = 18'h2A5C3;
      pulses = 0;
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
         issue(1'b1, lfsr[9:0], (lfsr[17:10] == 0) ? 1 : lfsr[17:10], "R4");
      end
      idle(14);
      check("R4", "stream pulses", pulses, 40);
   endtask

   // R5: alternating requests and bubbles
   task automatic t_bubbles();
      pulses = 0;
      for (int i = 0; i < 10; i++) begin
         issue(1'b1, 37 * i + 5, i + 2, "R5");
         issue(1'b0, 999, 1, "R5");
      end
      idle(14);
      check("R5", "bubble pulses", pulses, 10);
   endtask

   // R6: zero divisor mixed with nonzero neighbours
   task automatic t_divzero();
      pulses = 0;
      issue(1'b1, 1023, 0, "R6");
      issue(1'b1, 600, 7, "R6");
      issue(1'b1, 300, 0, "R6");
      issue(1'b1, 0, 0, "R6");
      issue(1'b1, 511, 2, "R6");
      idle(14);
      check("R6", "no stall pulses", pulses, 5);
   endtask

   initial begin
      t_reset();
      t_single();
      t_corners();
      t_stream();
      t_bubbles();
      t_divzero();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule